// File: doc/BRIEF.md
# Synchronous Flow-Through Static RAM

This block models a synchronous static RAM whose word is built from four byte lanes of nine bits each: eight data bits and one parity bit. The address, write data, chip enable, address strobe and every write control are captured on the rising clock edge. Only the output enable is not captured. It acts asynchronously on the read path, which the block presents as a data bus plus a separate drive-enable signal.

An active-low address strobe starts a new cycle. With chip enable high the cycle is a deselect. With chip enable low the cycle loads the external address and becomes a write if any write control is low, or a read if none is. While the strobe stays high, chip enable and the address inputs are ignored. An active device keeps working at the held address, and the write controls sampled on each edge choose between a read and a write. Reads are flow-through: the array is read combinationally at the registered address, so the data appears after the same edge that captured the address.

Top module: `sram_flowthru`

## Requirements
- R1: After reset the block is deselected and `rdata_oe` is low, even with `oe_n` low.
- R2: An edge with `strobe_n` low and `ce_n` high deselects the block: `rdata_oe` stays low whatever `oe_n` is.
- R3: An edge with `strobe_n` and `ce_n` both low, and with `gw_n` high and `bw_n` all ones, starts a read of `addr_in`. After that same edge, with `oe_n` low, `rdata` shows the stored word and `rdata_oe` is high.
- R4: While `strobe_n` is high, `ce_n` and `addr_in` have no effect. An ongoing read keeps returning the word at the held address.
- R5: With `gw_n` high, a write updates only the lanes whose `bw_n` bit is low. Bit i of `bw_n` controls word bits [9i+8:9i].
- R6: With `gw_n` low, a write updates all four lanes whatever `bw_n` is.
- R7: During a write cycle `rdata_oe` is low even when `oe_n` is low.
- R8: `oe_n` acts without a clock edge. During a read, raising it drops `rdata_oe` and lowering it restores `rdata_oe`.
- R9: A write issued with `strobe_n` high in an active cycle goes to the held address, not to `addr_in`.
- R10: While deselected with `strobe_n` high, the write controls leave the array unchanged.
- R11: Reset leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | Word address, taken when the strobe is low |
| wdata | input | 36 | Write word, four 9-bit lanes |
| strobe_n | input | 1 | Active-low address strobe |
| ce_n | input | 1 | Active-low chip enable, sampled with the strobe |
| gw_n | input | 1 | Active-low write of all lanes |
| bw_n | input | 4 | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 36 | Read word, zero when not driven |
| rdata_oe | output | 1 | High when `rdata` would drive the bus |

## Verification
The hardest case to reach is a cycle started without the strobe, where the address inputs must be ignored. A read begun at one address must be followed by edges with the strobe high and with different values on the address and chip enable. One such edge carries a write, which must land at the held address and leave the address on the pins untouched. The bench first fills a range of words with global writes. It then issues a strobed cycle, follows it with an unstrobed write to a different pin address, and reads both addresses back against a byte-masked reference array.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;
  localparam int LANES_DEF  = 4;
  localparam int LANE_W_DEF = 9;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_RD   = 2'd1,
    CYC_WR   = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_ft_cycle.sv
module sram_ft_cycle
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = LANES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              ce_n,
  input  logic              gw_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr_in,
  output cyc_e              cyc_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_go,
  output logic [ADDR_W-1:0] wr_addr
);
  cyc_e              cyc_d;
  logic [ADDR_W-1:0] addr_d;
  logic              wr_req;
  logic              addr_en;

  assign wr_req = !gw_n || (bw_n != {LANES{1'b1}});

  always_comb begin
    cyc_d   = cyc_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (!strobe_n) begin
      if (ce_n) begin
        cyc_d = CYC_IDLE;
      end else begin
        cyc_d   = wr_req ? CYC_WR : CYC_RD;
        addr_d  = addr_in;
        addr_en = 1'b1;
      end
    end else if (cyc_q != CYC_IDLE) begin
      cyc_d = wr_req ? CYC_WR : CYC_RD;
    end
  end

  assign wr_go   = rst_n && (cyc_d == CYC_WR);
  assign wr_addr = addr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= CYC_IDLE;
    end else begin
      cyc_q <= cyc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  // R2
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && ce_n) |=> (cyc_q == CYC_IDLE));

  // R3
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !ce_n) |=> (addr_q == $past(addr_in)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |=> $stable(addr_q));
endmodule

// File: rtl/sram_ft_lane_wen.sv
module sram_ft_lane_wen
  import sram_ft_pkg::*;
#(
  parameter int LANES = LANES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic             gw_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] we
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign we[l] = wr_go && (!gw_n || !bw_n[l]);
  end

  // R6
  global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !gw_n) |-> (&we));
endmodule

// File: rtl/sram_ft_store.sv
module sram_ft_store
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[l]) begin
        mem[wr_addr] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    assign rd_word[l*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/sram_flowthru.sv
module sram_flowthru
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    strobe_n,
  input  logic                    ce_n,
  input  logic                    gw_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int WORD_W = LANES * LANE_W;

  cyc_e              cyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_go;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  we;
  logic [WORD_W-1:0] rd_word;

  sram_ft_cycle #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cycle (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .ce_n(ce_n),
    .gw_n(gw_n), .bw_n(bw_n), .addr_in(addr_in),
    .cyc_q(cyc_q), .addr_q(addr_q), .wr_go(wr_go), .wr_addr(wr_addr)
  );

  sram_ft_lane_wen #(.LANES(LANES)) u_wen (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .gw_n(gw_n), .bw_n(bw_n), .we(we)
  );

  sram_ft_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .we(we), .wr_addr(wr_addr), .wdata(wdata),
    .rd_addr(addr_q), .rd_word(rd_word)
  );

  assign rdata_oe = (cyc_q == CYC_RD) && !oe_n;
  assign rdata    = rdata_oe ? rd_word : '0;

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !ce_n && !gw_n) |=> !rdata_oe);

  // R10
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && cyc_q == CYC_IDLE) |-> (we == '0));
endmodule

// File: tb/tb_sram_flowthru.sv
module tb_sram_flowthru;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [AW-1:0] addr_in;
  logic [35:0] wdata;
  logic        strobe_n, ce_n, gw_n, oe_n;
  logic [3:0]  bw_n;
  logic [35:0] rdata;
  logic        rdata_oe;

  logic [35:0] model [1<<AW];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_flowthru #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata(wdata),
    .strobe_n(strobe_n), .ce_n(ce_n), .gw_n(gw_n), .bw_n(bw_n),
    .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic g, input logic [3:0] b);
    logic [35:0] r = old;
    for (int l = 0; l < 4; l++)
      if (!g || !b[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  task automatic step(input logic s, input logic c, input logic g, input logic [3:0] b,
                      input logic [AW-1:0] a, input logic [35:0] d);
    strobe_n = s; ce_n = c; gw_n = g; bw_n = b; addr_in = a; wdata = d;
    @(posedge clk);
    #2;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [35:0] d,
                          input logic g, input logic [3:0] b);
    step(1'b0, 1'b0, g, b, a, d);
    model[a] = merge(model[a], d, g, b);
  endtask

  task automatic read_check(input logic [AW-1:0] a, input string tag);
    step(1'b0, 1'b0, 1'b1, 4'hF, a, '0);
    check(rdata_oe === 1'b1, tag, {35'd0, rdata_oe}, 36'd1);
    check(rdata === model[a], tag, rdata, model[a]);
  endtask

  task automatic t_reset;
    oe_n = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    check(rdata_oe === 1'b0, "R1 reset deselected", {35'd0, rdata_oe}, 36'd0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) do_write(AW'(i), {4{9'(i * 7 + 3)}}, 1'b0, 4'hF);
    do_write(8'd3, 36'h123456789, 1'b0, 4'b0101);
    read_check(8'd3, "R6 global write ignores lane enables");
    read_check(8'd7, "R6 global write fill");
  endtask

  task automatic t_byte;
    do_write(8'd5, 36'hABCDE0123, 1'b1, 4'b1010);
    read_check(8'd5, "R5 lanes 0 and 2");
    do_write(8'd6, 36'hFFFFFFFFF, 1'b1, 4'b0111);
    read_check(8'd6, "R5 lane 3 only");
  endtask

  task automatic t_flow;
    read_check(8'd9, "R3 flow-through read");
  endtask

  task automatic t_hold_read;
    read_check(8'd4, "R4 start read");
    step(1'b1, 1'b1, 1'b1, 4'hF, 8'd12, '0);
    check(rdata_oe === 1'b1, "R4 still driven", {35'd0, rdata_oe}, 36'd1);
    check(rdata === model[4], "R4 held address", rdata, model[4]);
  endtask

  task automatic t_oe;
    read_check(8'd2, "R8 read");
    oe_n = 1'b1; #1;
    check(rdata_oe === 1'b0, "R8 oe high off", {35'd0, rdata_oe}, 36'd0);
    oe_n = 1'b0; #1;
    check(rdata_oe === 1'b1, "R8 oe low on", {35'd0, rdata_oe}, 36'd1);
  endtask

  task automatic t_write_quiet;
    do_write(8'd10, 36'h0F0F0F0F0, 1'b0, 4'hF);
    check(rdata_oe === 1'b0, "R7 no drive in write", {35'd0, rdata_oe}, 36'd0);
    step(1'b1, 1'b1, 1'b0, 4'hF, 8'd11, 36'h5A5A5A5A5);
    model[10] = 36'h5A5A5A5A5;
    check(rdata_oe === 1'b0, "R7 continued write quiet", {35'd0, rdata_oe}, 36'd0);
    read_check(8'd10, "R9 write at held address");
    read_check(8'd11, "R9 pin address untouched");
  endtask

  task automatic t_deselect;
    step(1'b0, 1'b1, 1'b1, 4'hF, 8'd8, '0);
    check(rdata_oe === 1'b0, "R2 deselect", {35'd0, rdata_oe}, 36'd0);
    step(1'b1, 1'b0, 1'b0, 4'h0, 8'd8, 36'h777777777);
    check(rdata_oe === 1'b0, "R10 stays idle", {35'd0, rdata_oe}, 36'd0);
    read_check(8'd8, "R10 array unchanged");
  endtask

  task automatic t_reset_keep;
    rst_n = 1'b0;
    step(1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
    rst_n = 1'b1;
    read_check(8'd5, "R11 contents kept");
  endtask

  initial begin
    strobe_n = 1'b1; ce_n = 1'b1; gw_n = 1'b1; bw_n = 4'hF;
    addr_in = '0; wdata = '0; oe_n = 1'b0; rst_n = 1'b0;
    t_reset();
    t_fill();
    t_byte();
    t_flow();
    t_hold_read();
    t_oe();
    t_write_quiet();
    t_deselect();
    t_reset_keep();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule